// File: doc/BRIEF.md
# Two-Stage Resize Coefficient Engine

The engine turns a pair of image sizes into the control word that a scaler uses to step through its source pixels. For each dimension it first decides how many times the source size must be halved before fine scaling (zero, one or two times). It then computes a fixed-point step with thirteen fractional bits, using a radix-2 restoring divider. The vertical dimension is processed first and the horizontal second. The two results are then packed into one 32-bit word.

A client presents the four sizes and pulses `start` while the engine is idle. The engine samples the sizes, checks each dimension against its limits and runs the divider once per dimension. It then pulses `done`. If either dimension breaks a limit, the run stops at that point and the error flag is raised. In that case the packed word keeps the value from the last good run.

Top module: `rsz_coef_engine`

## Requirements
- R1: After reset, `rsz_word` is 0 and `err`, `done` and `busy` are all 0.
- R2: An input size above 4096 or an output size above 1024, in either dimension, ends the run with `err` = 1 on the `done` pulse, and `rsz_word` keeps its earlier value.
- R3: A run is rejected the same way when output × 8 is smaller than input in either dimension. A ratio of exactly 8:1 is accepted.
- R4: A run is rejected the same way when an output size is 0 or 1, or when an input size is 0.
- R5: The downsize code is the number of halvings applied to the input size, capped at two. A halving is applied while the current size is above 1024 or at least twice the output size. The code is never 3.
- R6: The coefficient equals floor(8192 × (halved size − 1) / (output size − 1)).
- R7: A coefficient of 16384 or more is replaced by 0x3FFF.
- R8: On success, the word holds the vertical code in bits [31:30], the vertical coefficient in [29:16], the horizontal code in [15:14] and the horizontal coefficient in [13:0]. The word changes only on the `done` pulse of a run that ends with `err` = 0.
- R9: `busy` is 1 from the cycle after an accepted `start` through the `done` cycle. `done` lasts exactly one cycle. A `start` that arrives while `busy` is 1 is ignored.
- R10: `err` is cleared when the next `start` is accepted, and it stays at its last value while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| in_h | input | 13 | Vertical input size |
| out_h | input | 11 | Vertical output size |
| in_w | input | 13 | Horizontal input size |
| out_w | input | 11 | Horizontal output size |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run was rejected |
| rsz_word | output | 32 | Packed resize control word |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that the size inputs are treated as don't-care except in the cycle that `start` is accepted. The engine samples the sizes at that point, so a later change cannot affect a run. The stimulus changes sizes only while `start` is high in an idle cycle, except in one directed case. That case deliberately pulses `start` with new sizes in the middle of a run to show that they are ignored. The vector table is ordered so that each rejected run follows a successful one with a distinct word, which makes it visible whether the word was held.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_V_CHECK,
        ST_V_DIV,
        ST_H_CHECK,
        ST_H_DIV,
        ST_FINISH,
        ST_REJECT
    } rsz_state_e;

endpackage

// File: rtl/rsz_limit_chk.sv
module rsz_limit_chk #(
    parameter int IN_W     = 13,
    parameter int OUT_W    = 11,
    parameter int MAX_IN   = 4096,
    parameter int MAX_OUT  = 1024,
    parameter int RATIO_SH = 3
) (
    input  logic [IN_W-1:0]  in_size,
    input  logic [OUT_W-1:0] out_size,
    output logic             bad
);
    localparam int CW = IN_W + OUT_W + RATIO_SH;

    logic [CW-1:0] in_x;
    logic [CW-1:0] out_x;
    logic          too_big_in;
    logic          too_big_out;
    logic          too_small;
    logic          too_steep;

    always_comb begin
        in_x        = CW'(in_size);
        out_x       = CW'(out_size);
        too_big_in  = in_x > CW'(MAX_IN);
        too_big_out = out_x > CW'(MAX_OUT);
        too_small   = (out_x < CW'(2)) || (in_x == '0);
        too_steep   = (out_x << RATIO_SH) < in_x;
        bad         = too_big_in || too_big_out || too_small || too_steep;
    end
endmodule

// File: rtl/rsz_halver.sv
module rsz_halver #(
    parameter int IN_W       = 13,
    parameter int OUT_W      = 11,
    parameter int HALF_MAX   = 2,
    parameter int HALF_LIMIT = 1024,
    localparam int DS_W      = $clog2(HALF_MAX + 1)
) (
    input  logic [IN_W-1:0]  in_size,
    input  logic [OUT_W-1:0] out_size,
    output logic [IN_W-1:0]  halved,
    output logic [DS_W-1:0]  code
);
    localparam int CW = IN_W + OUT_W + 1;

    logic [IN_W-1:0] sz [HALF_MAX+1];
    logic [HALF_MAX:0] go;
    logic [CW-1:0]   twice_out;

    assign sz[0]     = in_size;
    assign go[0]     = 1'b1;
    assign twice_out = CW'(out_size) << 1;

    for (genvar g = 0; g < HALF_MAX; g++) begin : g_stage
        logic shrink;
        assign shrink    = go[g] && ((CW'(sz[g]) > CW'(HALF_LIMIT)) ||
                                     (CW'(sz[g]) >= twice_out));
        assign go[g+1]   = shrink;
        assign sz[g+1]   = shrink ? (sz[g] >> 1) : sz[g];
    end

    assign halved = sz[HALF_MAX];

    always_comb begin
        code = '0;
        for (int i = 1; i <= HALF_MAX; i++) begin
            code = code + DS_W'(go[i]);
        end
    end
endmodule

// File: rtl/rsz_div_restore.sv
module rsz_div_restore #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem_q, num_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                num_q <= num;
                den_q <= den;
                rem_q <= '0;
                quo   <= '0;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                num_q <= num_q << 1;
                if (fits) begin
                    rem_q <= DEN_W'(trial - {1'b0, den_q});
                    quo   <= {quo[NUM_W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[DEN_W-1:0];
                    quo   <= {quo[NUM_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsz_coef_engine.sv
module rsz_coef_engine #(
    parameter int IN_W       = 13,
    parameter int OUT_W      = 11,
    parameter int MAX_IN     = 4096,
    parameter int MAX_OUT    = 1024,
    parameter int RATIO_SH   = 3,
    parameter int HALF_MAX   = 2,
    parameter int HALF_LIMIT = 1024,
    parameter int FRAC_W     = 13,
    parameter int COEF_W     = 14,
    localparam int DS_W      = $clog2(HALF_MAX + 1),
    localparam int FIELD_W   = DS_W + COEF_W,
    localparam int WORD_W    = 2 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IN_W-1:0]   in_h,
    input  logic [OUT_W-1:0]  out_h,
    input  logic [IN_W-1:0]   in_w,
    input  logic [OUT_W-1:0]  out_w,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rsz_word
);
    import rsz_pkg::*;

    localparam int NUM_W = IN_W + FRAC_W;

    rsz_state_e state_q, state_n;

    logic [IN_W-1:0]    ih_q, iw_q;
    logic [OUT_W-1:0]   oh_q, ow_q;
    logic [FIELD_W-1:0] v_field_q;
    logic [WORD_W-1:0]  word_q;
    logic               err_q;

    logic               horiz;
    logic [IN_W-1:0]    cur_in;
    logic [OUT_W-1:0]   cur_out;
    logic               cur_bad;
    logic [IN_W-1:0]    cur_half;
    logic [DS_W-1:0]    cur_code;
    logic               div_start;
    logic               div_done;
    logic [NUM_W-1:0]   div_num;
    logic [OUT_W-1:0]   div_den;
    logic [NUM_W-1:0]   div_quo;
    logic [COEF_W-1:0]  coef;
    logic               in_check;

    // dimension select follows the state
    always_comb begin
        horiz   = (state_q == ST_H_CHECK) || (state_q == ST_H_DIV);
        cur_in  = horiz ? iw_q : ih_q;
        cur_out = horiz ? ow_q : oh_q;
    end

    rsz_limit_chk #(
        .IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN),
        .MAX_OUT(MAX_OUT), .RATIO_SH(RATIO_SH)
    ) limit_i (
        .in_size(cur_in), .out_size(cur_out), .bad(cur_bad)
    );

    rsz_halver #(
        .IN_W(IN_W), .OUT_W(OUT_W), .HALF_MAX(HALF_MAX),
        .HALF_LIMIT(HALF_LIMIT)
    ) halver_i (
        .in_size(cur_in), .out_size(cur_out),
        .halved(cur_half), .code(cur_code)
    );

    always_comb begin
        div_num = {cur_half - 1'b1, {FRAC_W{1'b0}}};
        div_den = cur_out - 1'b1;
    end

    rsz_div_restore #(.NUM_W(NUM_W), .DEN_W(OUT_W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den),
        .done(div_done), .quo(div_quo)
    );

    // overflow clamp on the quotient
    always_comb begin
        if (|div_quo[NUM_W-1:COEF_W]) coef = '1;
        else                          coef = div_quo[COEF_W-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)    state_n = ST_V_CHECK;
            ST_V_CHECK: state_n = cur_bad ? ST_REJECT : ST_V_DIV;
            ST_V_DIV:   if (div_done) state_n = ST_H_CHECK;
            ST_H_CHECK: state_n = cur_bad ? ST_REJECT : ST_H_DIV;
            ST_H_DIV:   if (div_done) state_n = ST_FINISH;
            ST_FINISH:  state_n = ST_IDLE;
            ST_REJECT:  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_check  = (state_q == ST_V_CHECK) || (state_q == ST_H_CHECK);
        busy      = state_q != ST_IDLE;
        done      = (state_q == ST_FINISH) || (state_q == ST_REJECT);
        div_start = in_check && !cur_bad;
        err       = err_q;
        rsz_word  = word_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ih_q      <= '0;
            oh_q      <= '0;
            iw_q      <= '0;
            ow_q      <= '0;
            v_field_q <= '0;
            word_q    <= '0;
            err_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                ih_q  <= in_h;
                oh_q  <= out_h;
                iw_q  <= in_w;
                ow_q  <= out_w;
                err_q <= 1'b0;
            end
            if (in_check && cur_bad) err_q <= 1'b1;
            if (state_q == ST_V_DIV && div_done)
                v_field_q <= {cur_code, coef};
            if (state_q == ST_H_DIV && div_done)
                word_q <= {v_field_q, cur_code, coef};
        end
    end
endmodule

// File: rtl/rsz_coef_engine_chk.sv
module rsz_coef_engine_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [WORD_W-1:0] rsz_word
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_word_on_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsz_word) |-> (done && !err));

    assert_err_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err));

    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsz_word[31:30] != 2'b11) && (rsz_word[15:14] != 2'b11));
endmodule

bind rsz_coef_engine rsz_coef_engine_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .err(err), .rsz_word(rsz_word)
);

// File: tb/rsz_coef_engine_tb_top.sv
`timescale 1ns/100ps
module rsz_coef_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] in_h = '0, in_w = '0;
    logic [10:0] out_h = '0, out_w = '0;
    logic        busy, done, err;
    logic [31:0] rsz_word;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rsz_coef_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_h(in_h), .out_h(out_h), .in_w(in_w), .out_w(out_w),
        .busy(busy), .done(done), .err(err), .rsz_word(rsz_word)
    );

    // [80:68] in_h [67:57] out_h [56:44] in_w [43:33] out_w [32] err [31:0] word
    localparam int NV = 11;
    localparam logic [80:0] VEC [NV] = '{
        {13'd640,  11'd480,  13'd800,  11'd600,  1'b0, 32'h2AB0_2AAF}, // R6
        {13'd100,  11'd200,  13'd2,    11'd1024, 1'b0, 32'h0FEB_0008}, // R6 upscale
        {13'd4097, 11'd1024, 13'd640,  11'd480,  1'b1, 32'h0FEB_0008}, // R2 input
        {13'd1000, 11'd300,  13'd2400, 11'd300,  1'b0, 32'h7567_BFFF}, // R5 R7 R3 edge
        {13'd640,  11'd480,  13'd800,  11'd1025, 1'b1, 32'h7567_BFFF}, // R2 output
        {13'd3,    11'd2,    13'd16,   11'd2,    1'b0, 32'h3FFF_BFFF}, // R7 at 16384
        {13'd801,  11'd100,  13'd640,  11'd480,  1'b1, 32'h3FFF_BFFF}, // R3
        {13'd4096, 11'd1024, 13'd4096, 11'd1024, 1'b0, 32'hA000_A000}, // R5 R8
        {13'd640,  11'd480,  13'd50,   11'd1,    1'b1, 32'hA000_A000}, // R4 out 1
        {13'd1025, 11'd1024, 13'd1024, 11'd1024, 1'b0, 32'h4FFB_2000}, // R5 limit
        {13'd0,    11'd5,    13'd640,  11'd480,  1'b1, 32'h4FFB_2000}  // R4 in 0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [12:0] ih, input logic [10:0] oh,
                               input logic [12:0] iw, input logic [10:0] ow);
        @(negedge clk);
        in_h = ih; out_h = oh; in_w = iw; out_w = ow;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'd0, done}, 32'd1);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 word", rsz_word, 32'h0);
        check("R1 err", {31'd0, err}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after release", {30'd0, busy, done}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            pulse_start(VEC[i][80:68], VEC[i][67:57], VEC[i][56:44], VEC[i][43:33]);
            check("R9 busy after start", {31'd0, busy}, 32'd1);
            wait_done("R9 done");
            check("R2 R3 R4 err flag", {31'd0, err}, {31'd0, VEC[i][32]});
            check("R6 R7 R8 word", rsz_word, VEC[i][31:0]);
            @(negedge clk);
            check("R9 done width", {30'd0, done, busy}, 32'd0);
        end

        // R10: err cleared by next accepted start, held while idle
        pulse_start(13'd0, 11'd5, 13'd8, 11'd8);
        wait_done("R4 setup");
        repeat (5) @(negedge clk);
        check("R10 err held idle", {31'd0, err}, 32'd1);
        pulse_start(13'd640, 11'd480, 13'd800, 11'd600);
        check("R10 err cleared", {31'd0, err}, 32'd0);
        wait_done("R10 done");
        check("R8 word", rsz_word, 32'h2AB0_2AAF);

        // R9: start during a run is ignored
        pulse_start(13'd100, 11'd200, 13'd2, 11'd1024);
        repeat (6) @(negedge clk);
        in_h = 13'd4096; out_h = 11'd1024; in_w = 13'd4096; out_w = 11'd1024;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9 done busy case");
        check("R9 start ignored word", rsz_word, 32'h0FEB_0008);
        begin
            int extra = 0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            check("R9 no second run", extra, 0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule